// File: doc/BRIEF.md
# Serial Shift-Register Reader Controller

This controller collects a byte from an external parallel-in, serial-out shift register over three wires. It first pulls the active-low shift/load line down to capture the register's parallel inputs, then releases it to freeze the captured word. It then walks the word out one bit at a time. The first bit is read before any shift clock is issued. Each later bit is read after a low-then-high pulse on the shift clock, whose rising edge advances the external register by one stage.

The bits are gathered most-significant first. Once the word is complete, a one-cycle valid strobe is raised and the assembled value appears on a held output. After each transaction the controller waits through an idle interval and then starts the next read, so it polls the external register continuously from a single system clock.

The width of every low and high phase is a parameter counted in system clocks. The idle interval and the word width are also parameters.

Top module: `piso_reader`

## Requirements
- R1: While synchronous reset is applied, and in the first cycle after it, `dataValid` is 0 and `dataOut` is all zeros.
- R2: Each transaction holds `shLoadN` low (0 = capture parallel inputs) for exactly PHASE_CYCLES consecutive system clocks, once per transaction.
- R3: `shLoadN` and `shiftClk` are never low in the same cycle; the shift clock rests high (1) while the load is active.
- R4: Each transaction issues exactly DATA_W shift-clock pulses, each low for PHASE_CYCLES cycles and then high for PHASE_CYCLES cycles.
- R5: The first bit is sampled from `serIn` after the load is released and before the first shift-clock pulse, and lands in `dataOut[DATA_W-1]`.
- R6: Bit k sampled (k = 0 first) lands in `dataOut[DATA_W-1-k]`, so `dataOut` equals the word on the external parallel inputs at load time.
- R7: `dataValid` is high for exactly one cycle per transaction, in the cycle right after the high phase of the last shift-clock pulse.
- R8: `dataOut` changes only in a cycle where `dataValid` is high (or through reset) and otherwise holds the last published byte.
- R9: The load goes low exactly IDLE_CYCLES cycles after the valid cycle, with both outputs high during that idle time. Successive valid strobes are therefore IDLE_CYCLES + (2 + 2*DATA_W)*PHASE_CYCLES + 1 cycles apart.
- R10: A reset arriving at any point of a transaction leaves both outputs high in the next cycle. The idle timer then starts from zero, so the first load falls IDLE_CYCLES cycles after reset is released and no strobe from the aborted transaction appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data from the external register's output stage |
| shLoadN | output | 1 | Shift/load control, 0 captures parallel inputs, idles at 1 |
| shiftClk | output | 1 | Shift clock to the external register, idles at 1 |
| dataOut | output | DATA_W | Last assembled word, most-significant bit sampled first |
| dataValid | output | 1 | One-cycle strobe marking a new `dataOut` |

## Verification
The synchronous reset and the publishing of a finished word can land on the same clock edge. In that case the reset must win: no strobe appears and the output register clears.

The bench provokes this by watching the shift clock as it runs. It raises reset in the final cycle of the last high phase, so reset and the publish request share one edge. It then expects `dataValid` low, `dataOut` zero and both control lines high. The following transaction must arrive exactly one idle interval plus one full read after reset is released.

// File: rtl/piso_reader_pkg.sv
package piso_reader_pkg;

  typedef enum logic [2:0] {
    RD_IDLE    = 3'd0,
    RD_LOAD_LO = 3'd1,
    RD_LOAD_HI = 3'd2,
    RD_CLK_LO  = 3'd3,
    RD_CLK_HI  = 3'd4,
    RD_DONE    = 3'd5
  } rdState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clear;    // empty the assembly register at transaction start
    logic sample;   // shift serIn into the assembly register
    logic publish;  // copy the assembled word out and raise valid
  } rdStrobe_t;

endpackage

// File: rtl/piso_reader_ctrl.sv
module piso_reader_ctrl
  import piso_reader_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PHASE_CYCLES = 3,
  parameter int IDLE_CYCLES  = 20
) (
  input  logic      clk,
  input  logic      rst,
  output logic      shLoadN,
  output logic      shiftClk,
  output rdStrobe_t strobe
);

  localparam int PH      = (PHASE_CYCLES < 1) ? 1 : PHASE_CYCLES;
  localparam int IDL     = (IDLE_CYCLES < 1) ? 1 : IDLE_CYCLES;
  localparam int CNT_MAX = (PH > IDL) ? PH : IDL;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PH - 1);
  localparam logic [CNT_W-1:0] IDL_LAST = CNT_W'(IDL - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rdState_e         state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] pulseCnt;
  logic             phaseEnd;

  assign phaseEnd = (cnt == PH_LAST);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      RD_IDLE: begin
        if (cnt == IDL_LAST) begin
          stateNext    = RD_LOAD_LO;
          strobe.clear = 1'b1;
        end
      end
      RD_LOAD_LO: begin
        if (phaseEnd) stateNext = RD_LOAD_HI;
      end
      RD_LOAD_HI: begin
        // first bit is present right after the load: take it before any pulse
        if (phaseEnd) begin
          stateNext     = RD_CLK_LO;
          strobe.sample = 1'b1;
        end
      end
      RD_CLK_LO: begin
        if (phaseEnd) stateNext = RD_CLK_HI;
      end
      RD_CLK_HI: begin
        if (phaseEnd) begin
          if (pulseCnt == BIT_LAST) begin
            stateNext      = RD_DONE;
            strobe.publish = 1'b1;
          end else begin
            stateNext     = RD_CLK_LO;
            strobe.sample = 1'b1;
          end
        end
      end
      RD_DONE: stateNext = RD_IDLE;
      default: stateNext = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RD_IDLE;
      cnt      <= '0;
      pulseCnt <= '0;
      shLoadN  <= 1'b1;
      shiftClk <= 1'b1;
    end else begin
      state    <= stateNext;
      cnt      <= (stateNext != state) ? '0 : cnt + CNT_W'(1);
      if (state == RD_IDLE) begin
        pulseCnt <= '0;
      end else if (state == RD_CLK_HI && phaseEnd) begin
        pulseCnt <= pulseCnt + BIT_W'(1);
      end
      // outputs registered from the next state: glitch-free pins
      shLoadN  <= (stateNext != RD_LOAD_LO);
      shiftClk <= (stateNext != RD_CLK_LO);
    end
  end

endmodule

// File: rtl/piso_reader_dp.sv
module piso_reader_dp
  import piso_reader_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  rdStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  logic [DATA_W-1:0] assembleQ;

  // Shifting in at the bottom leaves the earliest sample on the top bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      assembleQ <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (strobe.clear) begin
        assembleQ <= '0;
      end else if (strobe.sample) begin
        assembleQ <= {assembleQ[DATA_W-2:0], serIn};
      end
      if (strobe.publish) begin
        dataOut <= assembleQ;
      end
      dataValid <= strobe.publish;
    end
  end

endmodule

// File: rtl/piso_reader.sv
module piso_reader
  import piso_reader_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PHASE_CYCLES = 3,
  parameter int IDLE_CYCLES  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  output logic              shLoadN,
  output logic              shiftClk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  rdStrobe_t strobe;

  piso_reader_ctrl #(
    .DATA_W      (DATA_W),
    .PHASE_CYCLES(PHASE_CYCLES),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .shLoadN (shLoadN),
    .shiftClk(shiftClk),
    .strobe  (strobe)
  );

  piso_reader_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .serIn    (serIn),
    .strobe   (strobe),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/piso_reader_chk.sv
module piso_reader_chk #(
  parameter int DATA_W       = 8,
  parameter int PHASE_CYCLES = 3,
  parameter int IDLE_CYCLES  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              shLoadN,
  input logic              shiftClk,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid
);

  localparam int PH  = (PHASE_CYCLES < 1) ? 1 : PHASE_CYCLES;
  localparam int IDL = (IDLE_CYCLES < 1) ? 1 : IDLE_CYCLES;

  int   loadRun;
  int   clkLowRun;
  int   pulseSeen;
  int   gap;
  logic clkPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadRun   <= 0;
      clkLowRun <= 0;
      pulseSeen <= 0;
      gap       <= 0;
      clkPrev   <= 1'b1;
    end else begin
      loadRun   <= shLoadN ? 0 : loadRun + 1;
      clkLowRun <= shiftClk ? 0 : clkLowRun + 1;
      clkPrev   <= shiftClk;
      if (!shLoadN)                pulseSeen <= 0;
      else if (shiftClk && !clkPrev) pulseSeen <= pulseSeen + 1;
      gap       <= dataValid ? 0 : gap + 1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dataValid && dataOut == '0)); // R1

  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (shLoadN && loadRun != 0) |-> (loadRun == PH)); // R2

  AST_LOAD_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!shLoadN && !shiftClk)); // R3

  AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (shiftClk && clkLowRun != 0) |-> (clkLowRun == PH)); // R4

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> (pulseSeen == DATA_W)); // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dataValid && !$past(rst)) |-> $stable(dataOut)); // R8

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(shLoadN) |-> (gap == IDL)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (shLoadN && shiftClk)); // R10

endmodule

bind piso_reader piso_reader_chk #(
  .DATA_W      (DATA_W),
  .PHASE_CYCLES(PHASE_CYCLES),
  .IDLE_CYCLES (IDLE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shLoadN  (shLoadN),
  .shiftClk (shiftClk),
  .dataOut  (dataOut),
  .dataValid(dataValid)
);

// File: tb/piso_reader_bench.sv
`timescale 1ns/1ps
module piso_reader_bench;

  localparam int DW     = 8;
  localparam int PH     = 3;
  localparam int IDL    = 20;
  localparam int PERIOD = IDL + (2 + 2 * DW) * PH + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          serIn = 1'b0;
  logic          shLoadN, shiftClk, dataValid;
  logic [DW-1:0] dataOut;

  always #2 clk = ~clk;

  piso_reader #(.DATA_W(DW), .PHASE_CYCLES(PH), .IDLE_CYCLES(IDL)) u_piso_reader (
    .clk(clk), .rst(rst), .serIn(serIn), .shLoadN(shLoadN),
    .shiftClk(shiftClk), .dataOut(dataOut), .dataValid(dataValid)
  );

  // external register model and observation state
  logic [DW-1:0] par = '0, extReg = '0, expWord = '0, expOut = '0;
  logic serFill = 1'b0;
  logic prevLoadN = 1'b1, prevClk = 1'b1, prevValid = 1'b0;
  int loadLow = 0, clkLow = 0, clkHigh = 0, rises = 0, sinceEvt = 0, nStrobes = 0;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] shiftIn(input logic [DW-1:0] r, input logic b);
    return {r[DW-2:0], b};
  endfunction

  task automatic tick();
    @(negedge clk);
    if (rst) begin
      sinceEvt = 1;
      chk(shLoadN && shiftClk, "R10 outputs high after reset", {shLoadN, shiftClk}, 3);
      chk(!dataValid && dataOut == '0, "R1 reset clears output", {dataValid, dataOut}, 0);
      expOut = '0; rises = 0; loadLow = 0; clkLow = 0; clkHigh = 0;
      prevLoadN = 1'b1; prevClk = 1'b1; prevValid = 1'b0;
    end else begin
      sinceEvt++;
      chk(!(!shLoadN && !shiftClk), "R3 load and clock both low", {shLoadN, shiftClk}, 2);
      if (!shLoadN) begin
        if (prevLoadN) chk(sinceEvt == IDL + 1, "R9 idle before load", sinceEvt, IDL + 1);
        loadLow++;
        extReg = par; expWord = par; rises = 0;
      end else if (!prevLoadN) begin
        chk(loadLow == PH, "R2 load width", loadLow, PH);
        loadLow = 0;
      end
      if (!shiftClk) begin
        if (prevClk && rises > 0) chk(clkHigh == PH, "R4 clock high width", clkHigh, PH);
        clkLow++;
      end else begin
        if (!prevClk) begin
          chk(clkLow == PH, "R4 clock low width", clkLow, PH);
          clkLow = 0; clkHigh = 0; rises++;
          extReg = shiftIn(extReg, serFill);
        end
        clkHigh++;
      end
      if (dataValid) begin
        chk(!prevValid, "R7 strobe one cycle", 1, 0);
        chk(sinceEvt == PERIOD, "R9 strobe spacing", sinceEvt, PERIOD);
        chk(rises == DW, "R4 pulse count", rises, DW);
        chk(shiftClk && shLoadN, "R7 strobe after last pulse", {shLoadN, shiftClk}, 3);
        chk(dataOut[DW-1] == expWord[DW-1], "R5 first bit to top", dataOut[DW-1], expWord[DW-1]);
        chk(dataOut == expWord, "R6 assembled word", dataOut, expWord);
        expOut = expWord; sinceEvt = 0; nStrobes++;
      end else begin
        chk(dataOut == expOut, "R8 output held", dataOut, expOut);
      end
      prevLoadN = shLoadN; prevClk = shiftClk; prevValid = dataValid;
    end
    serIn = extReg[DW-1];
  endtask

  task automatic runXfer(input logic [DW-1:0] word);
    int start = nStrobes;
    int guard = 0;
    par = word;
    serFill = 1'($urandom);
    while (nStrobes == start && guard < 2 * PERIOD) begin
      tick();
      guard++;
    end
    chk(nStrobes != start, "R7 strobe arrives", nStrobes - start, 1);
  endtask

  initial begin
    int guard;
    int held;
    void'($urandom(32'h1bad5eed));
    repeat (3) tick();
    rst = 1'b0;
    // directed corner words
    runXfer(8'h00); runXfer(8'hFF); runXfer(8'h80);
    runXfer(8'h7F); runXfer(8'h01); runXfer(8'hA5);
    for (int i = 0; i < 25; i++) runXfer(DW'($urandom));

    // reset coinciding with the publish edge (R1, R10)
    par = 8'h3C;
    guard = 0;
    do begin tick(); guard++; end
    while (!(rises == DW && clkHigh == PH && shiftClk) && guard < 2 * PERIOD);
    held = nStrobes;
    rst = 1'b1;
    tick();
    chk(!dataValid, "R1 reset beats strobe", dataValid, 0);
    chk(dataOut == '0, "R1 output cleared", dataOut, 0);
    rst = 1'b0;
    runXfer(8'hC3);
    chk(nStrobes == held + 1, "R10 aborted word not published", nStrobes - held, 1);

    // reset during the load pulse (R10)
    guard = 0;
    do begin tick(); guard++; end while (shLoadN && guard < 2 * PERIOD);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    runXfer(8'h5A);
    runXfer(DW'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule